// File: doc/BRIEF.md
# Gap-Tolerant Superpage Address Translator

This block turns a virtual address inside a 2 MB superpage into a physical address when the superpage is not backed by one contiguous, aligned 2 MB frame range. The physical backing lies inside a 4 MB-aligned slice, which is twice the superpage size. The slice is divided into 64 building blocks of 64 KB, and a 64-bit occupancy map marks which of those blocks hold the superpage. The virtual superpage is cut into 32 blocks of 64 KB. Virtual block number i is placed on the physical block at the i-th set map bit, counting set bits upward from map bit 0. Retired frames can therefore be skipped. When the map is one contiguous aligned half of the slice, the result is an ordinary superpage mapping.

Each request carries the virtual address, the slice base and the map, and is qualified by a valid strobe. The result comes out two clock cycles later. A map that does not have exactly half its bits set is malformed. For such a map the translator raises a fault instead of producing an address. The block sits after the translation-entry fetch and needs no storage of its own.

Top module: `gtsp_xlate`

## Requirements
- R1: A request accepted with `in_valid` high at a clock edge produces `out_valid` high exactly two edges later. `out_valid` is never high without a matching request.
- R2: For a well-formed map, `out_paddr[15:0]` equals `in_vaddr[15:0]` of the request.
- R3: For a well-formed map, `out_paddr[51:22]` equals `in_slice` of the request.
- R4: For a well-formed map, `out_paddr[21:16]` is the bit index of the n-th set bit of `in_map`, where n = `in_vaddr[20:16]`. Set bits are counted from zero, upward from bit 0.
- R5: A map with a population count other than 32 (zero, fewer or more) gives `out_fault` = 1 and `out_paddr` = 0 in the result cycle. A map with exactly 32 set bits gives `out_fault` = 0.
- R6: A map of `0x00000000FFFFFFFF` gives `in_slice`·4 MB + `in_vaddr[20:0]`. A map of `0xFFFFFFFF00000000` gives the same value plus 2 MB. Both are ordinary contiguous superpages.
- R7: Bits of `in_vaddr` at positions 21 and above have no effect on the result.
- R8: Requests on consecutive cycles are translated independently, and each result is delivered in order on consecutive cycles.
- R9: While reset is asserted, and until the first result, `out_valid`, `out_fault` and `out_paddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_vaddr | input | 48 | Virtual address to translate |
| in_slice | input | 30 | 4 MB-aligned physical slice number (physical address bits 51:22) |
| in_map | input | 64 | Occupancy map; bit k set means 64 KB physical block k of the slice is used |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_paddr | output | 52 | Translated physical address; zero on fault |
| out_fault | output | 1 | Malformed map (population count not 32) |

## Verification
The bench builds the translator with its default geometry: 64 KB blocks, a 2 MB superpage, a 4 MB slice and the one-hot prefix-count search. With these values the whole 64-bit map and all 32 virtual block indices can be exercised. This covers the first and last set bits, maps that leave the top physical block in use, and both contiguous halves. Pseudo-random 32-bit-populated maps reach arbitrary gap patterns. Maps with 0, 31, 33 and 64 set bits probe the fault boundary on both sides of the legal count.

// File: rtl/gtsp_pkg.sv
package gtsp_pkg;

   // Outcome of the second pipeline stage
   typedef enum logic [1:0] {
      XL_IDLE  = 2'd0,
      XL_OK    = 2'd1,
      XL_FAULT = 2'd2
   } xl_state_e;

   // Width of a counter able to hold the value w
   function automatic int unsigned cnt_width(input int unsigned w);
      return $clog2(w + 1);
   endfunction

endpackage

// File: rtl/gtsp_popcnt.sv
module gtsp_popcnt #(
   parameter  int unsigned W  = 64,
   localparam int unsigned CW = gtsp_pkg::cnt_width(W)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);

   if (W < 2) begin : g_bad_w
      $error("gtsp_popcnt: W must be at least 2");
   end

   always_comb begin
      cnt = '0;
      for (int k = 0; k < W; k++) begin
         cnt = cnt + CW'(vec[k]);
      end
   end

endmodule

// File: rtl/gtsp_nth_bit.sv
module gtsp_nth_bit #(
   parameter  int unsigned MAP_W  = 64,
   parameter  int unsigned IDX_W  = 5,
   parameter  bit          ONEHOT = 1'b1,
   localparam int unsigned POS_W  = $clog2(MAP_W),
   localparam int unsigned CW     = gtsp_pkg::cnt_width(MAP_W)
) (
   input  logic [MAP_W-1:0] map,
   input  logic [IDX_W-1:0] nth,
   output logic [POS_W-1:0] pos,
   output logic             found
);

   if ((1 << IDX_W) > MAP_W) begin : g_bad_idx
      $error("gtsp_nth_bit: ordinal range exceeds map width");
   end

   logic [CW-1:0] nth_w;
   assign nth_w = CW'(nth);

   if (ONEHOT) begin : g_prefix
      // Ripple prefix counts, then a one-hot match vector and an OR encoder
      logic [CW-1:0]    pre [MAP_W];
      logic [MAP_W-1:0] hit;

      assign pre[0] = '0;
      for (genvar k = 0; k < MAP_W; k++) begin : g_bit
         assign hit[k] = map[k] && (pre[k] == nth_w);
         if (k < MAP_W - 1) begin : g_next
            assign pre[k+1] = pre[k] + CW'(map[k]);
         end
      end

      always_comb begin
         pos = '0;
         for (int k = 0; k < MAP_W; k++) begin
            if (hit[k]) pos = pos | POS_W'(k);
         end
      end
      assign found = |hit;
   end else begin : g_scan
      // Priority scan: first set bit whose running count equals the ordinal
      logic [CW-1:0] seen;
      always_comb begin
         pos   = '0;
         found = 1'b0;
         seen  = '0;
         for (int k = 0; k < MAP_W; k++) begin
            if (map[k]) begin
               if (!found && seen == nth_w) begin
                  pos   = POS_W'(k);
                  found = 1'b1;
               end
               seen = seen + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/gtsp_xlate.sv
module gtsp_xlate #(
   parameter  int unsigned VA_W          = 48,
   parameter  int unsigned PA_W          = 52,
   parameter  int unsigned BLK_SH        = 16,
   parameter  int unsigned SP_SH         = 21,
   parameter  int unsigned SLICE_SH      = 22,
   parameter  bit          ONEHOT_SEARCH = 1'b1,
   localparam int unsigned IDX_W         = SP_SH - BLK_SH,
   localparam int unsigned POS_W         = SLICE_SH - BLK_SH,
   localparam int unsigned MAP_W         = 1 << POS_W,
   localparam int unsigned BASE_W        = PA_W - SLICE_SH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VA_W-1:0]   in_vaddr,
   input  logic [BASE_W-1:0] in_slice,
   input  logic [MAP_W-1:0]  in_map,
   output logic              out_valid,
   output logic [PA_W-1:0]   out_paddr,
   output logic              out_fault
);
   import gtsp_pkg::*;

   localparam int unsigned CW   = cnt_width(MAP_W);
   localparam int unsigned NEED = 1 << IDX_W;

   // Elaboration-time geometry checks
   if (SLICE_SH != SP_SH + 1) begin : g_bad_slice
      $error("gtsp_xlate: slice must be twice the superpage");
   end
   if (BLK_SH <= 12 || BLK_SH >= SP_SH) begin : g_bad_blk
      $error("gtsp_xlate: block must lie between 4 KB page and superpage");
   end
   if (VA_W <= SP_SH || PA_W <= SLICE_SH) begin : g_bad_addr
      $error("gtsp_xlate: address widths too small");
   end

   logic unused_va_hi;
   assign unused_va_hi = ^in_vaddr[VA_W-1:SP_SH];

   // ---------------- stage 1: register request, check population -----
   logic [CW-1:0] in_cnt;
   logic          in_bad;

   gtsp_popcnt #(.W(MAP_W)) u_pop (
      .vec (in_map),
      .cnt (in_cnt)
   );
   assign in_bad = (in_cnt != CW'(NEED));

   logic              s1_vld;
   logic              s1_bad;
   logic [IDX_W-1:0]  s1_idx;
   logic [BLK_SH-1:0] s1_off;
   logic [BASE_W-1:0] s1_base;
   logic [MAP_W-1:0]  s1_map;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_bad  <= 1'b0;
         s1_idx  <= '0;
         s1_off  <= '0;
         s1_base <= '0;
         s1_map  <= '0;
      end else begin
         s1_vld <= in_valid;
         if (in_valid) begin
            s1_bad  <= in_bad;
            s1_idx  <= in_vaddr[SP_SH-1:BLK_SH];
            s1_off  <= in_vaddr[BLK_SH-1:0];
            s1_base <= in_slice;
            s1_map  <= in_map;
         end
      end
   end

   // ---------------- stage 2: ordinal search and result ---------------
   logic [POS_W-1:0] blk_pos;
   logic             blk_found;

   gtsp_nth_bit #(
      .MAP_W  (MAP_W),
      .IDX_W  (IDX_W),
      .ONEHOT (ONEHOT_SEARCH)
   ) u_nth (
      .map   (s1_map),
      .nth   (s1_idx),
      .pos   (blk_pos),
      .found (blk_found)
   );

   xl_state_e s2_state;
   always_comb begin
      if (!s1_vld)     s2_state = XL_IDLE;
      else if (s1_bad) s2_state = XL_FAULT;
      else             s2_state = XL_OK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_fault <= 1'b0;
         out_paddr <= '0;
      end else begin
         out_valid <= (s2_state != XL_IDLE);
         out_fault <= (s2_state == XL_FAULT);
         out_paddr <= (s2_state == XL_OK) ? {s1_base, blk_pos, s1_off} : '0;
      end
   end

   // ---------------- assertions ---------------------------------------
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R4
   blk_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && !s1_bad) |-> (blk_found && s1_map[blk_pos]));

   // R1
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   // R2
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && out_valid && !out_fault)
         |-> (out_paddr[BLK_SH-1:0] == $past(in_vaddr[BLK_SH-1:0], 2)));

   // R3
   slice_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && out_valid && !out_fault)
         |-> (out_paddr[PA_W-1:SLICE_SH] == $past(in_slice, 2)));

   // R5
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_valid && out_paddr == '0));

endmodule

// File: tb/gtsp_xlate_test.sv
module gtsp_xlate_test;
   localparam int VA_W   = 48;
   localparam int PA_W   = 52;
   localparam int BASE_W = 30;
   localparam int MAP_W  = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [VA_W-1:0]   in_vaddr = '0;
   logic [BASE_W-1:0] in_slice = '0;
   logic [MAP_W-1:0]  in_map = '0;
   logic              out_valid;
   logic [PA_W-1:0]   out_paddr;
   logic              out_fault;

   always #2.5 clk = ~clk;

   gtsp_xlate uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
      .in_slice(in_slice), .in_map(in_map), .out_valid(out_valid),
      .out_paddr(out_paddr), .out_fault(out_fault)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   logic [PA_W-1:0] q_pa  [$];
   bit              q_f   [$];
   string           q_tag [$];

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: applies one request and pushes its expected outcome
   task automatic drive(input logic [VA_W-1:0] va, input logic [BASE_W-1:0] sb,
                        input logic [MAP_W-1:0] m, input string tag);
      int ones;
      int seen;
      int pos;
      @(negedge clk);
      in_valid = 1'b1;
      in_vaddr = va;
      in_slice = sb;
      in_map   = m;
      ones = 0;
      for (int k = 0; k < MAP_W; k++) ones += int'(m[k]);
      if (ones != 32) begin
         q_pa.push_back('0);
         q_f.push_back(1'b1);
      end else begin
         seen = 0;
         pos  = -1;
         for (int k = 0; k < MAP_W; k++) begin
            if (m[k]) begin
               if (seen == int'(va[20:16]) && pos < 0) pos = k;
               seen++;
            end
         end
         q_pa.push_back({sb, 6'(pos), va[15:0]});
         q_f.push_back(1'b0);
      end
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: pops the scoreboard whenever a result appears (R1, R8)
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid && !finished) begin
         if (q_pa.size() == 0) begin
            check(1'b0, "R1 unexpected out_valid", 64'(out_valid), 64'd0);
         end else begin
            logic [PA_W-1:0] epa;
            bit              ef;
            string           t;
            epa = q_pa.pop_front();
            ef  = q_f.pop_front();
            t   = q_tag.pop_front();
            check(out_paddr == epa, {t, " paddr"}, 64'(out_paddr), 64'(epa));
            check(out_fault == ef, {t, " fault"}, 64'(out_fault), 64'(ef));
         end
      end
   end

   logic [31:0] lfsr = 32'hACE1_2468;
   function automatic logic [31:0] step(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   initial begin
      logic [MAP_W-1:0] m;
      int               ones;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 64'd0);
      check(out_fault == 1'b0, "R9 out_fault", 64'(out_fault), 64'd0);
      check(out_paddr == '0, "R9 out_paddr", 64'(out_paddr), 64'd0);
      rst_n = 1'b1;
      idle(2);
      check(out_valid == 1'b0, "R1 idle no result", 64'(out_valid), 64'd0);

      // R6 contiguous halves, R2 R3 offsets and slice base
      drive(48'h0000_0000_0000, 30'h0000_0001, 64'h0000_0000_FFFF_FFFF, "R6 low half first");
      idle(1);
      drive(48'h0000_001F_FFFF, 30'h2ABC_DEF0, 64'h0000_0000_FFFF_FFFF, "R6 low half last");
      idle(2);
      drive(48'h0000_0012_3456, 30'h0000_0777, 64'hFFFF_FFFF_0000_0000, "R6 upper half");
      drive(48'h0000_001F_0001, 30'h3FFF_FFFF, 64'hFFFF_FFFF_0000_0000, "R6 upper top block");
      idle(1);

      // R4 gap patterns: alternating bits, nibble gaps
      drive(48'h0000_0000_BEEF, 30'h0000_0100, 64'h5555_5555_5555_5555, "R4 alternate idx0");
      drive(48'h0000_001F_BEEF, 30'h0000_0100, 64'hAAAA_AAAA_AAAA_AAAA, "R4 alternate idx31 top bit");
      drive(48'h0000_0005_0042, 30'h0000_0200, 64'h0F0F_0F0F_0F0F_0F0F, "R4 nibble gaps");
      drive(48'h0000_0010_8000, 30'h0000_0300, 64'hF0F0_F0F0_F0F0_F0F0, "R4 nibble gaps shifted");
      idle(1);

      // R7 upper vaddr bits ignored: same low bits, different high bits
      drive(48'h0000_000A_1234, 30'h0000_0055, 64'h0F0F_0F0F_0F0F_0F0F, "R7 high zero");
      drive(48'hFFFF_FFEA_1234, 30'h0000_0055, 64'h0F0F_0F0F_0F0F_0F0F, "R7 high ones");
      drive(48'h8A5C_3C2A_1234, 30'h0000_0055, 64'h0F0F_0F0F_0F0F_0F0F, "R7 high mixed");
      idle(1);

      // R5 malformed maps on both sides of the legal count
      drive(48'h0000_0001_0000, 30'h0000_0009, 64'h0000_0000_0000_0000, "R5 empty map");
      drive(48'h0000_0001_0000, 30'h0000_0009, 64'h0000_0000_7FFF_FFFF, "R5 31 set");
      drive(48'h0000_0001_0000, 30'h0000_0009, 64'h0000_0001_FFFF_FFFF, "R5 33 set");
      drive(48'h0000_0001_0000, 30'h0000_0009, 64'hFFFF_FFFF_FFFF_FFFF, "R5 full map");
      drive(48'h0000_0001_0000, 30'h0000_0009, 64'hFFFF_0000_0000_FFFF, "R5 legal after faults");
      idle(2);

      // R8 back-to-back mix of good and bad entries, then random gap maps (R4)
      for (int r = 0; r < 40; r++) begin
         m = '0;
         ones = 0;
         while (ones < 32) begin
            lfsr = step(lfsr);
            if (!m[lfsr[5:0]]) begin
               m[lfsr[5:0]] = 1'b1;
               ones++;
            end
         end
         lfsr = step(lfsr);
         if (r % 7 == 3) begin
            drive({lfsr[15:0], lfsr}, lfsr[29:0], m ^ 64'h1, "R8 back-to-back fault");
         end else begin
            drive({lfsr[15:0], lfsr}, lfsr[29:0], m, "R8 R4 random gaps");
         end
      end
      idle(6);
      check(q_pa.size() == 0, "R1 all results delivered", 64'(q_pa.size()), 64'd0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule